// File: doc/BRIEF.md
# Low-Frequency Clock Quality Monitor

This block judges the health of a slow (nominally 32 kHz) clock by timing it with a fast reference clock (nominally 48 MHz). One of two candidate slow inputs is picked by a control bit and passed through a double-flop synchronizer. The block then counts reference cycles from one rising edge to the next (the period) and from a rising edge to the following falling edge (the high time). Each completed period is compared with a programmable window. The change in high time from one period to the next is compared with a programmable limit.

Periods that pass all enabled checks are counted. Once that count reaches a programmable threshold, the clock is declared valid. Any failing period resets the count. A failure after the clock was valid is reported as a separate "unwell" event. A missing edge is reported as a stall once the period counter saturates. Every event sets a sticky status bit, which is cleared by writing a one to it. The interrupt output is raised whenever an enabled status bit is set.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge; reads are combinational.

Top module: `clk_quality_mon`

## Requirements
- R1: After reset every register reads 0, except the maximum period limit and the maximum high-time variation, which read all ones (0xFFFF). `irq_o` is low.
- R2: The word register map is:
  - 0: control
  - 1: measured period
  - 2: measured high time
  - 3: minimum period
  - 4: maximum period
  - 5: high-time variation
  - 6: maximum variation
  - 7: good-period count
  - 8: count threshold
  - 9: status
  - 10: interrupt enable
- R3: While control bit 0 is set, each rising edge after the first completes a period. It loads register 1 with the number of reference cycles between the two rising edges, loads register 2 with the number of cycles from the first rising edge to the falling edge between them, and sets status bit 0. While control bit 0 is clear, nothing is measured and no status bit is set.
- R4: A completed period with min ≤ period ≤ max sets status bit 1. Any other period sets status bit 3 (fail).
- R5: For each completed period that has a predecessor, register 5 is loaded with |high − previous high|. When control bit 1 is set, a variation above register 6 sets status bit 3, and otherwise sets status bit 2. The first period after arming is not compared.
- R6: While control bit 2 is set, each period with no fail adds one to the 8-bit count in register 7. The count saturates. Status bit 5 is set when the updated count is ≥ register 8. A fail resets the count to 0.
- R7: A fail that occurs after status bit 5 was last earned sets status bit 6 (unwell).
- R8: If no rising edge arrives within 65535 reference cycles of the previous rising edge, status bit 4 (stall) is set once. The count is reset to 0, and the next rising edge re-arms the measurement.
- R9: Writing control with bit 24 set zeroes registers 1, 2, 5 and 7 and disarms the measurement. Bit 24 always reads 0. Control bits 0, 1, 2 and 4 read back as written.
- R10: Status bits are cleared by writing 1 to them, and a bit set in the same cycle wins over the clear. `irq_o` is high exactly when some status bit and the same bit of register 10 are both set.
- R11: Control bit 4 = 0 monitors `lf_a_i`; bit 4 = 1 monitors `lf_b_i`. The unselected input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lf_a_i | input | 1 | Slow clock candidate A |
| lf_b_i | input | 1 | Slow clock candidate B |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong capture point in the period or high-time counters shows as an off-by-one value in registers 1 and 2. This appears within a few reference cycles after the closing rising edge. A judgement bit that is wrong, or a good-period count that is not reset, shows in the status word and in register 7 after the very next completed period, and a dropped enable shows the same way on `irq_o`. A stall detector that is wrong either fires while edges are still arriving or stays silent after the 65535-cycle limit. The bench probes just below and just above that limit.

// File: rtl/cqm_pkg.sv
package cqm_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned NSTS = 7;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_PER   = 4'd1;
  localparam logic [AW-1:0] A_HIGH  = 4'd2;
  localparam logic [AW-1:0] A_PMIN  = 4'd3;
  localparam logic [AW-1:0] A_PMAX  = 4'd4;
  localparam logic [AW-1:0] A_DV    = 4'd5;
  localparam logic [AW-1:0] A_DVMAX = 4'd6;
  localparam logic [AW-1:0] A_VCNT  = 4'd7;
  localparam logic [AW-1:0] A_VMIN  = 4'd8;
  localparam logic [AW-1:0] A_STS   = 4'd9;
  localparam logic [AW-1:0] A_IEN   = 4'd10;

  localparam int unsigned C_PER_EN = 0;
  localparam int unsigned C_DC_EN  = 1;
  localparam int unsigned C_VAL_EN = 2;
  localparam int unsigned C_SRC    = 4;
  localparam int unsigned C_CLR    = 24;

  localparam int unsigned S_RDY    = 0;
  localparam int unsigned S_PPER   = 1;
  localparam int unsigned S_PDC    = 2;
  localparam int unsigned S_FAIL   = 3;
  localparam int unsigned S_STALL  = 4;
  localparam int unsigned S_VALID  = 5;
  localparam int unsigned S_UNWELL = 6;
endpackage

// File: rtl/cqm_sync.sv
module cqm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-cycle delay
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], d_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cqm_meas.sv
module cqm_meas #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          done_o,
  output logic          stall_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] high_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt, high_cur;
  logic          armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      high_cur <= '0;
      armed    <= 1'b0;
      done_o   <= 1'b0;
      stall_o  <= 1'b0;
      per_o    <= '0;
      high_o   <= '0;
    end else if (clr_i) begin
      cnt      <= '0;
      high_cur <= '0;
      armed    <= 1'b0;
      done_o   <= 1'b0;
      stall_o  <= 1'b0;
      per_o    <= '0;
      high_o   <= '0;
    end else if (!en_i) begin
      cnt      <= '0;
      armed    <= 1'b0;
      done_o   <= 1'b0;
      stall_o  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      stall_o <= 1'b0;
      if (rise_i) begin
        cnt   <= CW'(1);
        armed <= 1'b1;
        if (armed) begin
          done_o <= 1'b1;
          per_o  <= cnt;
          high_o <= high_cur;
        end
      end else begin
        if (cnt != CMAX) cnt <= cnt + CW'(1);
        if (fall_i && armed) high_cur <= cnt;
        if (armed && cnt == CMAX) begin
          stall_o <= 1'b1;
          armed   <= 1'b0;
        end
      end
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/cqm_judge.sv
module cqm_judge
  import cqm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned VW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic            dc_en_i,
  input  logic            val_en_i,
  input  logic            done_i,
  input  logic            stall_i,
  input  logic [CW-1:0]   per_i,
  input  logic [CW-1:0]   high_i,
  input  logic [CW-1:0]   per_min_i,
  input  logic [CW-1:0]   per_max_i,
  input  logic [CW-1:0]   dv_max_i,
  input  logic [VW-1:0]   vmin_i,
  output logic [CW-1:0]   dv_o,
  output logic [VW-1:0]   vcnt_o,
  output logic [NSTS-1:0] set_o
);
  logic [CW-1:0] prev_high, dv_now;
  logic [VW-1:0] vnext;
  logic          have_prev, seen_valid;
  logic          per_ok, dc_chk, dc_ok, bad, reach;

  always_comb begin
    dv_now = (high_i >= prev_high) ? high_i - prev_high : prev_high - high_i;
    per_ok = (per_i >= per_min_i) && (per_i <= per_max_i);
    dc_chk = dc_en_i && have_prev;
    dc_ok  = dv_now <= dv_max_i;
    bad    = !per_ok || (dc_chk && !dc_ok);
    vnext  = (vcnt_o == '1) ? vcnt_o : vcnt_o + VW'(1);
    reach  = vnext >= vmin_i;
    set_o           = '0;
    set_o[S_RDY]    = done_i;
    set_o[S_PPER]   = done_i && per_ok;
    set_o[S_PDC]    = done_i && dc_chk && dc_ok;
    set_o[S_FAIL]   = done_i && bad;
    set_o[S_STALL]  = stall_i;
    set_o[S_VALID]  = done_i && !bad && val_en_i && reach;
    set_o[S_UNWELL] = done_i && bad && seen_valid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_high  <= '0;
      have_prev  <= 1'b0;
      seen_valid <= 1'b0;
      dv_o       <= '0;
      vcnt_o     <= '0;
    end else if (clr_i) begin
      prev_high  <= '0;
      have_prev  <= 1'b0;
      seen_valid <= 1'b0;
      dv_o       <= '0;
      vcnt_o     <= '0;
    end else if (stall_i) begin
      have_prev <= 1'b0;
      vcnt_o    <= '0;
    end else if (!en_i) begin
      have_prev <= 1'b0;
    end else if (done_i) begin
      prev_high <= high_i;
      have_prev <= 1'b1;
      if (have_prev) dv_o <= dv_now;
      if (bad) begin
        vcnt_o     <= '0;
        seen_valid <= 1'b0;
      end else if (val_en_i) begin
        vcnt_o <= vnext;
        if (reach) seen_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_quality_mon.sv
module clk_quality_mon
  import cqm_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned VW          = 8,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lf_a_i,
  input  logic          lf_b_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic          per_en_q, dc_en_q, val_en_q, src_q;
  logic [CW-1:0] per_min_q, per_max_q, dv_max_q;
  logic [VW-1:0] vmin_q;
  logic [NSTS-1:0] sts_q, ien_q, set_w, w1c;
  logic          clr_w, lf_sel, rise_w, fall_w, done_w, stall_w;
  logic [CW-1:0] per_w, high_w, dv_w, run_cnt_w;
  logic [VW-1:0] vcnt_w;

  assign clr_w  = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[C_CLR];
  assign w1c    = (reg_we_i && reg_addr_i == A_STS) ? reg_wdata_i[NSTS-1:0] : '0;
  assign lf_sel = src_q ? lf_b_i : lf_a_i;

  cqm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(lf_sel), .rise_o(rise_w), .fall_o(fall_w)
  );

  cqm_meas #(.CW(CW)) u_meas (
    .clk_i, .rst_ni, .en_i(per_en_q), .clr_i(clr_w),
    .rise_i(rise_w), .fall_i(fall_w),
    .done_o(done_w), .stall_o(stall_w),
    .per_o(per_w), .high_o(high_w), .cnt_o(run_cnt_w)
  );

  cqm_judge #(.CW(CW), .VW(VW)) u_judge (
    .clk_i, .rst_ni, .clr_i(clr_w), .en_i(per_en_q),
    .dc_en_i(dc_en_q), .val_en_i(val_en_q),
    .done_i(done_w), .stall_i(stall_w),
    .per_i(per_w), .high_i(high_w),
    .per_min_i(per_min_q), .per_max_i(per_max_q),
    .dv_max_i(dv_max_q), .vmin_i(vmin_q),
    .dv_o(dv_w), .vcnt_o(vcnt_w), .set_o(set_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_en_q  <= 1'b0;
      dc_en_q   <= 1'b0;
      val_en_q  <= 1'b0;
      src_q     <= 1'b0;
      per_min_q <= '0;
      per_max_q <= '1;
      dv_max_q  <= '1;
      vmin_q    <= '0;
      ien_q     <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        A_CTRL: begin
          per_en_q <= reg_wdata_i[C_PER_EN];
          dc_en_q  <= reg_wdata_i[C_DC_EN];
          val_en_q <= reg_wdata_i[C_VAL_EN];
          src_q    <= reg_wdata_i[C_SRC];
        end
        A_PMIN:  per_min_q <= reg_wdata_i[CW-1:0];
        A_PMAX:  per_max_q <= reg_wdata_i[CW-1:0];
        A_DVMAX: dv_max_q  <= reg_wdata_i[CW-1:0];
        A_VMIN:  vmin_q    <= reg_wdata_i[VW-1:0];
        A_IEN:   ien_q     <= reg_wdata_i[NSTS-1:0];
        default: ;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~w1c) | set_w;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[C_PER_EN] = per_en_q;
        reg_rdata_o[C_DC_EN]  = dc_en_q;
        reg_rdata_o[C_VAL_EN] = val_en_q;
        reg_rdata_o[C_SRC]    = src_q;
      end
      A_PER:   reg_rdata_o[CW-1:0]   = per_w;
      A_HIGH:  reg_rdata_o[CW-1:0]   = high_w;
      A_PMIN:  reg_rdata_o[CW-1:0]   = per_min_q;
      A_PMAX:  reg_rdata_o[CW-1:0]   = per_max_q;
      A_DV:    reg_rdata_o[CW-1:0]   = dv_w;
      A_DVMAX: reg_rdata_o[CW-1:0]   = dv_max_q;
      A_VCNT:  reg_rdata_o[VW-1:0]   = vcnt_w;
      A_VMIN:  reg_rdata_o[VW-1:0]   = vmin_q;
      A_STS:   reg_rdata_o[NSTS-1:0] = sts_q;
      A_IEN:   reg_rdata_o[NSTS-1:0] = ien_q;
      default: ;
    endcase
  end

  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/clk_quality_mon_chk.sv
module clk_quality_mon_chk
  import cqm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned VW = 8,
  parameter int unsigned DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic            irq_o,
  input logic [NSTS-1:0] sts_q,
  input logic [NSTS-1:0] ien_q,
  input logic [NSTS-1:0] set_w,
  input logic            done_w,
  input logic            stall_w,
  input logic [VW-1:0]   vcnt_w,
  input logic [CW-1:0]   per_w,
  input logic [CW-1:0]   run_cnt_w
);
  localparam logic [CW-1:0] CMAX = '1;

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[C_CLR]) |=> (vcnt_w == '0 && per_w == '0)); // R9

  AST_FAIL_DROPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w[S_FAIL] |=> vcnt_w == '0); // R6

  AST_STALL_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_w |-> run_cnt_w == CMAX); // R8

  AST_DONE_SETS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |=> sts_q[S_RDY]); // R3

  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R10

  AST_W1C_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_STS && (&reg_wdata_i[NSTS-1:0]) && set_w == '0) |=> sts_q == '0); // R10
endmodule

bind clk_quality_mon clk_quality_mon_chk #(.CW(CW), .VW(VW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .sts_q(sts_q), .ien_q(ien_q),
  .set_w(set_w), .done_w(done_w), .stall_w(stall_w), .vcnt_w(vcnt_w),
  .per_w(per_w), .run_cnt_w(run_cnt_w)
);

// File: tb/clk_quality_mon_bench.sv
`timescale 1ns/1ps
module clk_quality_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_a = 1'b0, lf_b = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          errors = 0, checks = 0;

  localparam logic [3:0] CTRL = 0, PER = 1, HIGH = 2, PMIN = 3, PMAX = 4,
                         DV = 5, DVMAX = 6, VCNT = 7, VMIN = 8, STS = 9, IEN = 10;
  localparam logic [31:0] CLR = 32'h0100_0000;

  always #2 clk = ~clk;

  clk_quality_mon u_clk_quality_mon (
    .clk_i(clk), .rst_ni(rst_n), .lf_a_i(lf_a), .lf_b_i(lf_b),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic set_lf(input bit b, input logic v);
    if (b) lf_b = v; else lf_a = v;
  endtask

  task automatic period(input int p, input int h, input bit b = 1'b0);
    @(negedge clk); set_lf(b, 1'b1);
    repeat (h) @(negedge clk);
    set_lf(b, 1'b0);
    repeat (p - h - 1) @(negedge clk);
  endtask

  task automatic fin(input bit b = 1'b0);
    @(negedge clk); set_lf(b, 1'b1);
    repeat (4) @(negedge clk);
    set_lf(b, 1'b0);
    repeat (10) @(negedge clk);
  endtask

  task automatic restart(input logic [31:0] ctrl);
    wr(CTRL, CLR | ctrl);
    wr(STS, 32'h7F);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(CTRL, v);  check("R1 ctrl", v, 0);
    rd(STS, v);   check("R1 status", v, 0);
    rd(PMAX, v);  check("R1 pmax", v, 32'hFFFF);
    rd(DVMAX, v); check("R1 dvmax", v, 32'hFFFF);
    rd(VCNT, v);  check("R1 vcnt", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    wr(PMIN, 90); wr(PMAX, 110); wr(DVMAX, 3); wr(VMIN, 4); wr(IEN, 32'h08);
    rd(PMIN, v); check("R2 pmin map", v, 90);

    // R3/R4/R6/R10 period sweep across the window
    for (int p = 80; p <= 120; p += 5) begin
      bit bad;
      bad = (p < 90) || (p > 110);
      restart(32'h7);
      period(p, p / 2); period(p, p / 2); fin();
      rd(PER, v);  check("R3 period", v, p);
      rd(HIGH, v); check("R3 high", v, p / 2);
      rd(STS, s);
      check("R3 rdy bit", {31'd0, s[0]}, 1);
      check("R4 fail bit", {31'd0, s[3]}, {31'd0, bad});
      check("R4 pass bit", {31'd0, s[1]}, {31'd0, !bad});
      rd(VCNT, v); check("R6 count", v, bad ? 0 : 2);
      check("R10 irq follows fail", {31'd0, irq}, {31'd0, bad});
    end

    // R5 high-time variation sweep
    for (int d = 0; d <= 5; d++) begin
      restart(32'h7);
      period(100, 50); period(100, 50 + d); fin();
      rd(DV, v); check("R5 dv value", v, d);
      rd(STS, s);
      check("R5 fail on variation", {31'd0, s[3]}, {31'd0, d > 3});
      check("R5 duty pass", {31'd0, s[2]}, {31'd0, d <= 3});
    end

    // R6 threshold reached exactly at the minimum
    restart(32'h7);
    repeat (3) period(100, 50); fin();
    rd(VCNT, v); check("R6 count below min", v, 3);
    rd(STS, s);  check("R6 no valid below min", {31'd0, s[5]}, 0);
    restart(32'h7);
    repeat (4) period(100, 50); fin();
    rd(VCNT, v); check("R6 count at min", v, 4);
    rd(STS, s);  check("R6 valid at min", {31'd0, s[5]}, 1);

    // R9 clear bit
    wr(CTRL, CLR | 32'h7);
    rd(CTRL, v); check("R9 ctrl readback", v, 32'h7);
    rd(VCNT, v); check("R9 vcnt cleared", v, 0);
    rd(PER, v);  check("R9 period cleared", v, 0);

    // R7 unwell after valid, and not without it
    wr(VMIN, 2);
    restart(32'h7);
    period(100, 50); period(100, 50); period(130, 50); fin();
    rd(STS, s);
    check("R7 valid earned", {31'd0, s[5]}, 1);
    check("R7 unwell set", {31'd0, s[6]}, 1);
    rd(VCNT, v); check("R6 fail zeroes count", v, 0);

    // R10 write-one-to-clear only the written bit
    wr(STS, 32'h08);
    rd(STS, v); check("R10 w1c single bit", v, s & ~32'h08);
    wr(IEN, 0);
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(IEN, 32'h40);
    check("R10 irq unwell enabled", {31'd0, irq}, 1);
    wr(IEN, 0);

    restart(32'h7);
    period(130, 50); fin();
    rd(STS, s);
    check("R7 fail without valid", {31'd0, s[3]}, 1);
    check("R7 no unwell without valid", {31'd0, s[6]}, 0);

    // R3 disabled measurement
    restart(32'h0);
    repeat (3) period(100, 50); fin();
    rd(PER, v); check("R3 disabled period", v, 0);
    rd(STS, v); check("R3 disabled status", v, 0);

    // R11 source select
    restart(32'h17);
    repeat (3) period(100, 50); fin();
    rd(PER, v); check("R11 unselected a ignored", v, 0);
    rd(STS, v); check("R11 unselected status", v, 0);
    period(97, 40, 1'b1); fin(1'b1);
    rd(PER, v);  check("R11 b measured", v, 97);
    rd(HIGH, v); check("R11 b high", v, 40);

    // R8 stall
    wr(VMIN, 4);
    restart(32'h7);
    period(100, 50); period(100, 50); fin();
    rd(VCNT, v); check("R8 count before stall", v, 2);
    repeat (65000) @(negedge clk);
    rd(STS, s); check("R8 no stall early", {31'd0, s[4]}, 0);
    repeat (700) @(negedge clk);
    rd(STS, s); check("R8 stall flagged", {31'd0, s[4]}, 1);
    rd(VCNT, v); check("R8 count reset by stall", v, 0);

    summary();
  end
endmodule